// File: doc/BRIEF.md
# Open-Drain Serial Clock Synchronizer and Stretcher

This block produces the master clock waveform for a two-wire serial bus whose clock line is open drain and wired-AND. It does not drive the line high. It only switches on a pull-down, and it reads the line back through `scl_in`. Each phase is timed against the level the bus actually shows. If another master ends the high phase early, that shortened high is accepted. If another device holds the line low, the block waits for the line to return high. As a result, the shortest high and the longest low among all devices set the bus clock.

The block also paces the data path. When the data path reports that a byte and its acknowledge bit have finished, the block raises a serial interrupt flag. It then keeps the clock line low until software clears that flag. Two single-cycle strobes go to the data shifter:
- one in the middle of each high phase, for sampling data;
- one at the start of each pulled-low phase, for changing data.

Top module: `scl_sync_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs read 0 after that edge: `scl_pull`, `si_flag`, `sample_stb` and `change_stb`.
- R2: A value below 4 on `hi_period` or `lo_period` is treated as 4. Values of 4 to 255 are used unchanged.
- R3: With `gen_en` high and no other device on the line, the block asserts `scl_pull` for exactly eff_lo cycles. It then leaves the line released for exactly eff_hi+1 cycles, and the pattern repeats.
- R4: If `scl_in` reads 0 during a high phase, `scl_pull` goes to 1 at the next clock. A fresh low count of eff_lo cycles then starts, whoever drove the line low.
- R5: When its own low count expires, the block releases the line. It waits as long as `scl_in` reads 0. The high count starts on the clock after the first cycle in which `scl_in` reads 1.
- R6: A `byte_done` pulse sets `si_flag` at the next clock, and `si_clr` clears it at the next clock. If both are high in the same cycle, the flag is set.
- R7: While `si_flag` is 1, a low phase does not end and `scl_pull` stays 1. After `si_flag` falls, `scl_pull` stays 1 for exactly eff_lo more cycles.
- R8: `sample_stb` is high for one cycle per high phase. That cycle is the one whose high-count index is floor(eff_hi/2), where index 0 is the first high-phase cycle. The strobe fires only if `scl_in` reads 1 in that cycle.
- R9: `change_stb` is high for exactly one cycle: the first cycle of each stretch in which `scl_pull` is 1.
- R10: When `gen_en` is 0 at a clock edge, `scl_pull` is 0 and no strobe fires after that edge. When `gen_en` returns, the block first waits for the line to read high. `si_flag` keeps working in the meantime.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_en | input | 1 | Enables master clock generation |
| hi_period | input | 8 | High phase length in system clocks (minimum 4) |
| lo_period | input | 8 | Low phase length in system clocks (minimum 4) |
| scl_in | input | 1 | Sampled level of the bus clock line |
| byte_done | input | 1 | Pulse: byte plus acknowledge bit finished |
| si_clr | input | 1 | Clears the serial interrupt flag |
| scl_pull | output | 1 | 1 enables the open-drain pull-down on the clock line |
| si_flag | output | 1 | Serial interrupt flag |
| sample_stb | output | 1 | One-cycle strobe at mid high phase |
| change_stb | output | 1 | One-cycle strobe just after the clock falls |

## Verification
`scl_pull`, `si_flag` and `change_stb` are register outputs, so each changes one clock after the input or count event that causes it. `sample_stb` also depends on the current `scl_in`, so it responds to the line level within the same cycle. The bench drives every input on the falling clock edge. It compares all outputs 1 ns later against a per-cycle model built from the requirements, which steps once per cycle, after that comparison. Directed scenarios measure the lengths of bus-low and bus-high runs, counted in whole cycles. They check those lengths only after the next run has begun, so each result is read at least one cycle after it is due.

// File: rtl/scl_sync_pkg.sv
`timescale 1ns/1ps
package scl_sync_pkg;
    localparam int CNT_W   = 8;
    localparam int MIN_CNT = 4;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e phase;
        cnt_t   cnt;
    } phase_st_t;

    // Raise a configured period to the smallest supported length
    function automatic cnt_t clamp_period(cnt_t raw);
        return (raw < cnt_t'(MIN_CNT)) ? cnt_t'(MIN_CNT) : raw;
    endfunction

    function automatic cnt_t mid_point(cnt_t eff);
        return eff >> 1;
    endfunction
endpackage

// File: rtl/scl_irq_flag.sv
`timescale 1ns/1ps
module scl_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic byte_done,
    input  logic si_clr,
    output logic si_flag
);
    always_ff @(posedge clk) begin
        if (rst)
            si_flag <= 1'b0;
        else if (byte_done)
            si_flag <= 1'b1;
        else if (si_clr)
            si_flag <= 1'b0;
    end

    // R6
    si_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(si_flag) |-> $past(byte_done));
    // R6
    si_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (si_flag && !si_clr) |=> si_flag);
    // R6
    si_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(si_flag) |-> ($past(si_clr) && !$past(byte_done)));
endmodule

// File: rtl/scl_phase_fsm.sv
`timescale 1ns/1ps
module scl_phase_fsm
    import scl_sync_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      gen_en,
    input  logic      scl_in,
    input  logic      si_flag,
    input  cnt_t      hi_eff,
    input  cnt_t      lo_eff,
    output phase_st_t st,
    output phase_e    nxt_phase
);
    phase_st_t nxt;

    always_comb begin
        nxt = st;
        if (!gen_en) begin
            nxt.phase = PH_IDLE;
            nxt.cnt   = '0;
        end else begin
            case (st.phase)
                PH_IDLE: begin
                    nxt.phase = PH_WAIT;
                    nxt.cnt   = '0;
                end
                PH_LOW: begin
                    if (si_flag) begin
                        nxt.cnt = '0;
                    end else if (st.cnt == lo_eff - cnt_t'(1)) begin
                        nxt.phase = PH_WAIT;
                        nxt.cnt   = '0;
                    end else begin
                        nxt.cnt = st.cnt + cnt_t'(1);
                    end
                end
                PH_WAIT: begin
                    if (scl_in) begin
                        nxt.phase = PH_HIGH;
                        nxt.cnt   = '0;
                    end
                end
                PH_HIGH: begin
                    if (!scl_in || (st.cnt == hi_eff - cnt_t'(1))) begin
                        nxt.phase = PH_LOW;
                        nxt.cnt   = '0;
                    end else begin
                        nxt.cnt = st.cnt + cnt_t'(1);
                    end
                end
                default: begin
                    nxt.phase = PH_IDLE;
                    nxt.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.phase <= PH_IDLE;
            st.cnt   <= '0;
        end else begin
            st <= nxt;
        end
    end

    assign nxt_phase = nxt.phase;

    // R4
    hi_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (gen_en && st.phase == PH_HIGH && !scl_in) |=> (st.phase == PH_LOW));
    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gen_en && st.phase == PH_WAIT && !scl_in) |=> (st.phase == PH_WAIT));
    // R7
    stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gen_en && st.phase == PH_LOW && si_flag) |=> (st.phase == PH_LOW));
    // R10
    disable_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !gen_en |=> (st.phase == PH_IDLE));
endmodule

// File: rtl/scl_strobe_gen.sv
`timescale 1ns/1ps
module scl_strobe_gen
    import scl_sync_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  phase_st_t st,
    input  phase_e    nxt_phase,
    input  logic      scl_in,
    input  cnt_t      hi_eff,
    output logic      sample_stb,
    output logic      change_stb
);
    logic fell_q;

    always_ff @(posedge clk) begin
        if (rst)
            fell_q <= 1'b0;
        else
            fell_q <= (nxt_phase == PH_LOW) && (st.phase != PH_LOW);
    end

    assign change_stb = fell_q;
    assign sample_stb = (st.phase == PH_HIGH) && scl_in &&
                        (st.cnt == mid_point(hi_eff));

    // R8 R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(sample_stb && change_stb));
    // R9
    change_low_chk: assert property (@(posedge clk) disable iff (rst)
        change_stb |-> (st.phase == PH_LOW));
    // R9
    change_single_chk: assert property (@(posedge clk) disable iff (rst)
        change_stb |=> !change_stb);
endmodule

// File: rtl/scl_sync_gen.sv
`timescale 1ns/1ps
module scl_sync_gen
    import scl_sync_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       gen_en,
    input  logic [7:0] hi_period,
    input  logic [7:0] lo_period,
    input  logic       scl_in,
    input  logic       byte_done,
    input  logic       si_clr,
    output logic       scl_pull,
    output logic       si_flag,
    output logic       sample_stb,
    output logic       change_stb
);
    cnt_t      hi_eff;
    cnt_t      lo_eff;
    phase_st_t st;
    phase_e    nxt_phase;

    assign hi_eff = clamp_period(cnt_t'(hi_period));
    assign lo_eff = clamp_period(cnt_t'(lo_period));

    scl_irq_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .byte_done (byte_done),
        .si_clr    (si_clr),
        .si_flag   (si_flag)
    );

    scl_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .gen_en    (gen_en),
        .scl_in    (scl_in),
        .si_flag   (si_flag),
        .hi_eff    (hi_eff),
        .lo_eff    (lo_eff),
        .st        (st),
        .nxt_phase (nxt_phase)
    );

    scl_strobe_gen u_stb (
        .clk        (clk),
        .rst        (rst),
        .st         (st),
        .nxt_phase  (nxt_phase),
        .scl_in     (scl_in),
        .hi_eff     (hi_eff),
        .sample_stb (sample_stb),
        .change_stb (change_stb)
    );

    assign scl_pull = (st.phase == PH_LOW);

    // R10
    no_pull_off_chk: assert property (@(posedge clk) disable iff (rst)
        !gen_en |=> (!scl_pull && !sample_stb && !change_stb));
    // R9
    change_pull_chk: assert property (@(posedge clk) disable iff (rst)
        change_stb |-> scl_pull);
endmodule

// File: tb/sim_scl_sync_gen.sv
`timescale 1ns/1ps
module sim_scl_sync_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       gen_en = 1'b0;
    logic [7:0] hi_period = 8'd5;
    logic [7:0] lo_period = 8'd2;
    logic       ext_low = 1'b0;
    logic       byte_done = 1'b0;
    logic       si_clr = 1'b0;
    logic       scl_pull, si_flag, sample_stb, change_stb;
    logic       scl_bus;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_bus = !(scl_pull || ext_low);

    scl_sync_gen u0 (
        .clk        (clk),
        .rst        (rst),
        .gen_en     (gen_en),
        .hi_period  (hi_period),
        .lo_period  (lo_period),
        .scl_in     (scl_bus),
        .byte_done  (byte_done),
        .si_clr     (si_clr),
        .scl_pull   (scl_pull),
        .si_flag    (si_flag),
        .sample_stb (sample_stb),
        .change_stb (change_stb)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff(input int c);
        return (c < 4) ? 4 : c;
    endfunction

    // Reference model: 0 idle, 1 pulling low, 2 waiting for high, 3 high count
    int m_ph = 0, m_cnt = 0;
    bit m_si = 1'b0, m_fell = 1'b0, m_started = 1'b0;
    // Bus run-length monitor
    int run_len = 0, last_lo = 0, last_hi = 0;
    bit prev_bus = 1'b1;

    always @(negedge clk) begin
        int n_ph, n_cnt;
        #1;
        if (m_started && !rst) begin
            check("R4 scl_pull", int'(scl_pull), int'(m_ph == 1));
            check("R6 si_flag", int'(si_flag), int'(m_si));
            check("R8 sample_stb", int'(sample_stb),
                  int'(m_ph == 3 && m_cnt == eff(hi_period) / 2 && scl_bus));
            check("R9 change_stb", int'(change_stb), int'(m_fell));
        end
        if (scl_bus == prev_bus) run_len++;
        else begin
            if (prev_bus) last_hi = run_len; else last_lo = run_len;
            run_len = 1;
        end
        prev_bus = scl_bus;
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_si = 0; m_fell = 0; m_started = 1;
        end else begin
            n_ph = m_ph; n_cnt = m_cnt;
            if (!gen_en) begin n_ph = 0; n_cnt = 0; end
            else case (m_ph)
                0: begin n_ph = 2; n_cnt = 0; end
                1: if (m_si) n_cnt = 0;
                   else if (m_cnt == eff(lo_period) - 1) begin n_ph = 2; n_cnt = 0; end
                   else n_cnt = m_cnt + 1;
                2: if (scl_bus) begin n_ph = 3; n_cnt = 0; end
                default: if (!scl_bus || m_cnt == eff(hi_period) - 1) begin n_ph = 1; n_cnt = 0; end
                         else n_cnt = m_cnt + 1;
            endcase
            m_fell = (n_ph == 1) && (m_ph != 1);
            if (byte_done) m_si = 1; else if (si_clr) m_si = 0;
            m_ph = n_ph; m_cnt = n_cnt;
        end
    end

    task automatic wait_pull(input logic v);
        do @(negedge clk); while (scl_pull != v);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 scl_pull", int'(scl_pull), 0);
        check("R1 si_flag", int'(si_flag), 0);
        check("R1 strobes", int'(sample_stb | change_stb), 0);
        rst = 1'b0;

        // R2 clamp: lo 2 -> 4, hi 5; R3 released run hi+1
        gen_en = 1'b1;
        repeat (40) @(negedge clk);
        check("R2 low run", last_lo, 4);
        check("R3 high run", last_hi, 6);

        lo_period = 8'd10; hi_period = 8'd8;
        repeat (60) @(negedge clk);
        check("R3 low run", last_lo, 10);
        check("R3 high run", last_hi, 9);

        // R5 another device holds the line low beyond own count
        wait_pull(1'b0); wait_pull(1'b1);
        ext_low = 1'b1;
        repeat (16) @(negedge clk);
        ext_low = 1'b0;
        repeat (10) @(negedge clk);
        check("R5 stretched low run", last_lo, 16);
        check("R5 following high run", last_hi, 9);

        // R4 another master cuts the high phase short
        wait_pull(1'b0);
        repeat (2) @(negedge clk);
        ext_low = 1'b1;
        @(negedge clk);
        ext_low = 1'b0;
        repeat (11) @(negedge clk);
        check("R4 cut high run", last_hi, 2);
        check("R4 low run after cut", last_lo, 11);

        // R6 / R7 byte complete stretch
        wait_pull(1'b0); wait_pull(1'b1);
        byte_done = 1'b1;
        @(negedge clk);
        byte_done = 1'b0;
        repeat (9) @(negedge clk);
        byte_done = 1'b1; si_clr = 1'b1;
        @(negedge clk);
        byte_done = 1'b0; si_clr = 1'b0;
        check("R6 set wins over clear", int'(si_flag), 1);
        repeat (19) @(negedge clk);
        check("R7 still pulling", int'(scl_pull), 1);
        check("R7 flag held", int'(si_flag), 1);
        si_clr = 1'b1;
        @(negedge clk);
        si_clr = 1'b0;
        repeat (12) @(negedge clk);
        check("R7 stretched low run", last_lo, 41);
        check("R6 flag cleared", int'(si_flag), 0);

        // R10 disable releases the line
        wait_pull(1'b1);
        gen_en = 1'b0;
        begin
            int seen = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                #1;
                seen += int'(scl_pull | sample_stb | change_stb);
            end
            check("R10 outputs quiet while disabled", seen, 0);
        end
        gen_en = 1'b1;

        // Random traffic checked cycle by cycle against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (i % 500 == 0) begin
                hi_period = 8'($urandom % 16);
                lo_period = 8'($urandom % 16);
            end
            ext_low   = ext_low ? (($urandom % 4) != 0) : (($urandom % 25) == 0);
            byte_done = ($urandom % 60) == 0;
            si_clr    = si_flag && (($urandom % 10) == 0);
            gen_en    = ($urandom % 200) != 0;
        end
        ext_low = 1'b0; byte_done = 1'b0; si_clr = 1'b0;
        repeat (5) @(negedge clk);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule